// File: doc/BRIEF.md
# Uniform Random Tensor Fill Engine

This block takes one decoded fill command and writes a three-dimensional tensor of single-precision floats. Each value is drawn uniformly from a range whose two ends come from the command. A xorwow generator produces one 32-bit word per element. The top 23 bits of that word become a fraction in [0,1). The fraction is then scaled by the range width and offset by the lower bound in fp32.

Each bound is either carried inside the command or fetched from memory through a one-word read port. The fetch address comes either from the command field itself or from a register input. The block walks the destination with three signed strides and three counts and issues one address/data write per element on a valid/ready port. It pulses a completion flag once the last write has been accepted. If the command names any algorithm, post-process, output format or bound source other than the supported ones, the block pulses an error flag and neither reads nor writes.

Top module: `urand_fill`

## Requirements
- R1: The generator holds five xorshift words x,y,z,w,v and a Weyl word d. Each draw does four things: t = x^(x>>2); the words shift down (x<=y, y<=z, z<=w, w<=v); v <= (v^(v<<4))^(t^(t<<1)); d <= d+362437. The draw word is the new v plus the new d. Each element consumes exactly one draw, in write order.
- R2: A seed pulse while idle loads all six words at once from seed_data, with x in bits 31:0, then y, z, w, v, and d in bits 191:160. If bits 159:0 are all zero, the five xorshift words are set to 123456789, 362436069, 521288629, 88675123, 5783321, while d still takes its seed value. Reset loads those same five words with d = 0.
- R3: The fraction is formed by placing draw bits 31:9 into the mantissa of 0x3F800000 and subtracting 1.0. The result is frac23 / 2^23.
- R4: Each element equals lo + fraction*(hi-lo), computed in fp32 with truncation toward zero and with denormal results flushed to zero. The result is exact whenever the exact value is representable. When it is not, a positive result never exceeds the exact value and stays within a few ulps of it.
- R5: The bound source codes are 0 for an immediate value in the command field, 1 for an address held in the command field, and 2 for an address taken from reg_lo_ptr or reg_hi_ptr. The lower bound is fetched before the upper bound. No write occurs until every pointer-sourced bound has returned.
- R6: Elements are visited with dimension 0 innermost and dimension 2 outermost. Element (i0,i1,i2) is written at cmd_base + 4*(i0*s0 + i1*s1 + i2*s2), where each stride is a signed 16-bit element count.
- R7: A command is rejected when the algorithm code is not 3, the post-process code is not 1, the format is neither 0x0A nor 0x0B, or either source code is 3. On rejection, err pulses for one cycle after acceptance, no read or write is issued, and cmd_ready stays high.
- R8: A write held back by wr_ready low keeps its address and data unchanged until it is accepted. No element is lost or repeated.
- R9: done pulses for one cycle, in the cycle after the last write is accepted. A command with any count of zero pulses done with no writes.
- R10: cmd_ready is low from acceptance of a legal command until done, and commands offered during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| seed_valid | input | 1 | Load generator state (honoured while idle) |
| seed_data | input | 192 | Six 32-bit state words |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and taking a command |
| cmd_alg | input | 8 | Algorithm code (3 accepted) |
| cmd_post | input | 8 | Post-process code (1 accepted) |
| cmd_fmt | input | 8 | Output format code (0x0A or 0x0B accepted) |
| cmd_lo_src | input | 2 | Lower bound source code |
| cmd_hi_src | input | 2 | Upper bound source code |
| cmd_lo | input | 32 | Lower bound value or pointer |
| cmd_hi | input | 32 | Upper bound value or pointer |
| cmd_base | input | 32 | Destination byte address of element 0 |
| cmd_stride | input | 3x16 | Signed element strides, dimension 0 in bits 15:0 |
| cmd_count | input | 3x16 | Element counts, dimension 0 in bits 15:0 |
| reg_lo_ptr | input | 32 | Register pointer for the lower bound (code 2) |
| reg_hi_ptr | input | 32 | Register pointer for the upper bound (code 2) |
| rd_req_valid | output | 1 | Bound read request |
| rd_req_ready | input | 1 | Read request taken |
| rd_req_addr | output | 32 | Bound read address |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 32 | fp32 bound value |
| wr_valid | output | 1 | Element write offered |
| wr_ready | input | 1 | Element write taken |
| wr_addr | output | 32 | Element byte address |
| wr_data | output | 32 | Element fp32 value |
| done | output | 1 | Completion pulse |
| err | output | 1 | Rejected-command pulse |

## Verification
Several ranges are used because each exposes a different fault. The ranges [0,1), [2,4) and [-1,1) give exact results, so any error in the draw order, the mantissa fill or the multiply-add shows up bit for bit. The range [0.1,0.7) is inexact and shows whether truncation goes toward zero and the error stays small. The strides mix positive and negative values and the counts have unequal sizes, which separates the loop nesting order from the stride signs. Each bound source code is tried for both bounds, which catches swapped pointers and a wrong fetch order. A run after seeding all zeros separates the default substitution from a plain load. Random write backpressure shows whether data is held or dropped. The reject codes, the zero-count command and commands offered while busy exercise the paths that must write nothing.

// File: rtl/urand_fill.sv
module urand_fill #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        seed_valid,
  input  logic [191:0]                seed_data,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic [7:0]                  cmd_alg,
  input  logic [7:0]                  cmd_post,
  input  logic [7:0]                  cmd_fmt,
  input  logic [1:0]                  cmd_lo_src,
  input  logic [1:0]                  cmd_hi_src,
  input  logic [31:0]                 cmd_lo,
  input  logic [31:0]                 cmd_hi,
  input  logic [ADDR_W-1:0]           cmd_base,
  input  logic [2:0][CNT_W-1:0]       cmd_stride,
  input  logic [2:0][CNT_W-1:0]       cmd_count,
  input  logic [ADDR_W-1:0]           reg_lo_ptr,
  input  logic [ADDR_W-1:0]           reg_hi_ptr,
  output logic                        rd_req_valid,
  input  logic                        rd_req_ready,
  output logic [ADDR_W-1:0]           rd_req_addr,
  input  logic                        rd_rsp_valid,
  input  logic [31:0]                 rd_rsp_data,
  output logic                        wr_valid,
  input  logic                        wr_ready,
  output logic [ADDR_W-1:0]           wr_addr,
  output logic [31:0]                 wr_data,
  output logic                        done,
  output logic                        err
);
  localparam logic [31:0] WEYL_INC = 32'd362437;
  localparam logic [31:0] DX0 = 32'd123456789, DX1 = 32'd362436069, DX2 = 32'd521288629,
                          DX3 = 32'd88675123,  DX4 = 32'd5783321;
  localparam logic [31:0] ONE_F = 32'h3F800000, NEG_ONE_F = 32'hBF800000;
  localparam int XW = ADDR_W - CNT_W;

  typedef enum logic [2:0] {S_IDLE, S_RDLO, S_WLO, S_RDHI, S_WHI, S_PREP, S_RUN} st_t;

  function automatic logic [31:0] fp_add(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] x, y;
    logic [49:0] mx, my, sh, msk;
    logic [50:0] r, rn;
    int ex, ey, d, p, er;
    x = a; y = b;
    if (b[30:0] > a[30:0]) begin x = b; y = a; end
    ex = int'(x[30:23]); ey = int'(y[30:23]);
    if (ex == 0) return 32'h0;
    if (ey == 0) return x;
    mx = {1'b1, x[22:0], 26'b0};
    my = {1'b1, y[22:0], 26'b0};
    d  = ex - ey;
    if (d > 49) sh = 50'd1;
    else begin
      msk = (50'd1 << d) - 50'd1;
      sh  = my >> d;
      sh[0] = sh[0] | (|(my & msk));
    end
    if (x[31] == y[31]) r = {1'b0, mx} + {1'b0, sh};
    else                r = {1'b0, mx} - {1'b0, sh};
    if (r == 51'd0) return 32'h0;
    p = 0;
    for (int i = 0; i < 51; i++) if (r[i]) p = i;
    if (p == 50) begin
      rn = {1'b0, r[50:1]};
      rn[0] = r[1] | r[0];
      er = ex + 1;
    end else begin
      rn = r << (49 - p);
      er = ex - (49 - p);
    end
    if (er <= 0)   return 32'h0;
    if (er >= 255) return {x[31], 8'hFE, 23'h7FFFFF};
    return {x[31], 8'(er), rn[48:26]};
  endfunction

  function automatic logic [31:0] fp_mul(input logic [31:0] a, input logic [31:0] b);
    logic [47:0] pr;
    logic [22:0] m;
    int er;
    if (a[30:23] == 8'd0 || b[30:23] == 8'd0) return 32'h0;
    pr = 48'({1'b1, a[22:0]}) * 48'({1'b1, b[22:0]});
    er = int'(a[30:23]) + int'(b[30:23]) - 127;
    if (pr[47]) begin m = pr[46:24]; er = er + 1; end
    else m = pr[45:23];
    if (er <= 0)   return 32'h0;
    if (er >= 255) return {a[31] ^ b[31], 8'hFE, 23'h7FFFFF};
    return {a[31] ^ b[31], 8'(er), m};
  endfunction

  st_t st;
  logic [31:0] x0, x1, x2, x3, x4, wc;
  logic [31:0] lo_q, hi_q, diff_q;
  logic [ADDR_W-1:0] lo_ptr_q, hi_ptr_q, base_q;
  logic hi_need_q, more_q, wv_q, done_q, err_q;
  logic [ADDR_W-1:0] wa_q;
  logic [31:0] wd_q;
  logic [2:0][CNT_W-1:0] stride_q, cnt_q, idx_q;
  logic signed [ADDR_W-1:0] off0, off1, off2;

  logic [31:0] t, nv, nw, draw, frac, elem;
  logic bad, ld, fin, zero_cnt, last0, last1, last2;
  logic signed [ADDR_W-1:0] st0, st1, st2, off1n, off2n;

  assign t     = x0 ^ (x0 >> 2);
  assign nv    = (x4 ^ (x4 << 4)) ^ (t ^ (t << 1));
  assign nw    = wc + WEYL_INC;
  assign draw  = nv + nw;
  assign frac  = fp_add(ONE_F | {9'd0, draw[31:9]}, NEG_ONE_F);
  assign elem  = fp_add(lo_q, fp_mul(frac, diff_q));

  assign bad = (cmd_alg != 8'd3) || (cmd_post != 8'd1) ||
               !(cmd_fmt == 8'h0A || cmd_fmt == 8'h0B) ||
               (cmd_lo_src == 2'd3) || (cmd_hi_src == 2'd3);

  assign st0   = {{XW{stride_q[0][CNT_W-1]}}, stride_q[0]};
  assign st1   = {{XW{stride_q[1][CNT_W-1]}}, stride_q[1]};
  assign st2   = {{XW{stride_q[2][CNT_W-1]}}, stride_q[2]};
  assign off1n = off1 + st1;
  assign off2n = off2 + st2;
  assign last0 = idx_q[0] == cnt_q[0] - 1'b1;
  assign last1 = idx_q[1] == cnt_q[1] - 1'b1;
  assign last2 = idx_q[2] == cnt_q[2] - 1'b1;
  assign zero_cnt = (cnt_q[0] == '0) || (cnt_q[1] == '0) || (cnt_q[2] == '0);

  assign ld  = (st == S_RUN) && more_q && (!wv_q || wr_ready);
  assign fin = (st == S_RUN) && !more_q && wv_q && wr_ready;

  assign cmd_ready    = (st == S_IDLE);
  assign rd_req_valid = (st == S_RDLO) || (st == S_RDHI);
  assign rd_req_addr  = (st == S_RDHI) ? hi_ptr_q : lo_ptr_q;
  assign wr_valid     = wv_q;
  assign wr_addr      = wa_q;
  assign wr_data      = wd_q;
  assign done         = done_q;
  assign err          = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0 <= DX0; x1 <= DX1; x2 <= DX2; x3 <= DX3; x4 <= DX4; wc <= '0;
    end else if (st == S_IDLE && seed_valid) begin
      if (seed_data[159:0] == '0) begin
        x0 <= DX0; x1 <= DX1; x2 <= DX2; x3 <= DX3; x4 <= DX4;
      end else begin
        x0 <= seed_data[31:0];   x1 <= seed_data[63:32];  x2 <= seed_data[95:64];
        x3 <= seed_data[127:96]; x4 <= seed_data[159:128];
      end
      wc <= seed_data[191:160];
    end else if (ld) begin
      x0 <= x1; x1 <= x2; x2 <= x3; x3 <= x4; x4 <= nv; wc <= nw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      lo_q <= '0; hi_q <= '0; diff_q <= '0;
      lo_ptr_q <= '0; hi_ptr_q <= '0; base_q <= '0; hi_need_q <= 1'b0;
      stride_q <= '0; cnt_q <= '0; idx_q <= '0;
      off0 <= '0; off1 <= '0; off2 <= '0; more_q <= 1'b0;
      wv_q <= 1'b0; wa_q <= '0; wd_q <= '0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          if (bad) err_q <= 1'b1;
          else begin
            lo_q      <= cmd_lo;
            hi_q      <= cmd_hi;
            lo_ptr_q  <= (cmd_lo_src == 2'd2) ? reg_lo_ptr : cmd_lo[ADDR_W-1:0];
            hi_ptr_q  <= (cmd_hi_src == 2'd2) ? reg_hi_ptr : cmd_hi[ADDR_W-1:0];
            hi_need_q <= cmd_hi_src != 2'd0;
            base_q    <= cmd_base;
            stride_q  <= cmd_stride;
            cnt_q     <= cmd_count;
            st <= (cmd_lo_src != 2'd0) ? S_RDLO : (cmd_hi_src != 2'd0) ? S_RDHI : S_PREP;
          end
        end
        S_RDLO: if (rd_req_ready) st <= S_WLO;
        S_WLO: if (rd_rsp_valid) begin
          lo_q <= rd_rsp_data;
          st   <= hi_need_q ? S_RDHI : S_PREP;
        end
        S_RDHI: if (rd_req_ready) st <= S_WHI;
        S_WHI: if (rd_rsp_valid) begin
          hi_q <= rd_rsp_data;
          st   <= S_PREP;
        end
        S_PREP: begin
          diff_q <= fp_add(hi_q, {~lo_q[31], lo_q[30:0]});
          idx_q  <= '0;
          off0 <= '0; off1 <= '0; off2 <= '0;
          more_q <= 1'b1;
          if (zero_cnt) begin done_q <= 1'b1; st <= S_IDLE; end
          else st <= S_RUN;
        end
        S_RUN: begin
          if (ld) begin
            wv_q <= 1'b1;
            wa_q <= base_q + {off0[ADDR_W-3:0], 2'b00};
            wd_q <= elem;
            more_q <= !(last0 && last1 && last2);
            if (!last0) begin
              idx_q[0] <= idx_q[0] + 1'b1;
              off0 <= off0 + st0;
            end else if (!last1) begin
              idx_q[0] <= '0;
              idx_q[1] <= idx_q[1] + 1'b1;
              off1 <= off1n; off0 <= off1n;
            end else begin
              idx_q[0] <= '0; idx_q[1] <= '0;
              idx_q[2] <= idx_q[2] + 1'b1;
              off2 <= off2n; off1 <= off2n; off0 <= off2n;
            end
          end else if (wr_ready) wv_q <= 1'b0;
          if (fin) begin done_q <= 1'b1; st <= S_IDLE; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module urand_fill_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        rd_req_valid,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [31:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        done,
  input logic        err
);
  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid || rd_req_valid) |-> !cmd_ready);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid && cmd_ready);
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> cmd_ready && !wr_valid && !rd_req_valid);
  p_flag_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));
  p_rd_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !wr_valid);
endmodule

bind urand_fill urand_fill_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rd_req_valid(rd_req_valid),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .done(done), .err(err)
);

// File: tb/urand_fill_tb.sv
module urand_fill_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic seed_valid = 1'b0;
  logic [191:0] seed_data = '0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [7:0] cmd_alg = 8'd3, cmd_post = 8'd1, cmd_fmt = 8'h0A;
  logic [1:0] cmd_lo_src = 2'd0, cmd_hi_src = 2'd0;
  logic [31:0] cmd_lo = '0, cmd_hi = '0, cmd_base = '0;
  logic [2:0][15:0] cmd_stride = '0, cmd_count = '0;
  logic [31:0] reg_lo_ptr = 32'h240, reg_hi_ptr = 32'h340;
  logic rd_req_valid, rd_req_ready = 1'b0;
  logic [31:0] rd_req_addr;
  logic rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic wr_valid, wr_ready = 1'b0;
  logic [31:0] wr_addr, wr_data;
  logic done, err;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [31:0] mx [5];
  logic [31:0] mw;

  urand_fill u_dut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run hung, actual cycles=%0d expected done earlier", cyc);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic real f2r(input logic [31:0] b);
    real v;
    int e;
    e = int'(b[30:23]);
    if (e == 0) return 0.0;
    v = 1.0 + real'(b[22:0]) / 8388608.0;
    e = e - 127;
    while (e > 0) begin v = v * 2.0; e--; end
    while (e < 0) begin v = v / 2.0; e++; end
    return b[31] ? -v : v;
  endfunction

  task automatic model_seed(input logic [31:0] s0, s1, s2, s3, s4, w);
    if ({s0, s1, s2, s3, s4} == '0) begin
      mx[0] = 32'd123456789; mx[1] = 32'd362436069; mx[2] = 32'd521288629;
      mx[3] = 32'd88675123;  mx[4] = 32'd5783321;
    end else begin
      mx[0] = s0; mx[1] = s1; mx[2] = s2; mx[3] = s3; mx[4] = s4;
    end
    mw = w;
  endtask

  task automatic model_draw(output logic [31:0] r);
    logic [31:0] t;
    t = mx[0] ^ (mx[0] >> 2);
    mx[0] = mx[1]; mx[1] = mx[2]; mx[2] = mx[3]; mx[3] = mx[4];
    mx[4] = (mx[4] ^ (mx[4] << 4)) ^ (t ^ (t << 1));
    mw = mw + 32'd362437;
    r = mx[4] + mw;
  endtask

  task automatic seed_load(input logic [31:0] s0, s1, s2, s3, s4, w);
    @(negedge clk);
    seed_valid = 1'b1;
    seed_data = {w, s4, s3, s2, s1, s0};
    @(negedge clk);
    seed_valid = 1'b0;
    model_seed(s0, s1, s2, s3, s4, w);
  endtask

  task automatic run(input logic [31:0] lo, hi, input logic [1:0] ls, hs, input logic [31:0] base,
                     input int s0, s1, s2, c0, c1, c2, input bit exact, input bit bp, input bit poke,
                     input string tag);
    int total, k, j0, j1, j2, rdn, it;
    bit pend, got_done;
    logic [31:0] r, ea, pa;
    real lr, hr, f, ex, dr, tol;
    total = c0 * c1 * c2;
    k = 0; j0 = 0; j1 = 0; j2 = 0; rdn = 0; pend = 0; got_done = 0; it = 0;
    lr = f2r(lo); hr = f2r(hi);
    @(negedge clk);
    cmd_lo = (ls == 2'd0) ? lo : (ls == 2'd1) ? 32'h200 : 32'hDEAD0;
    cmd_hi = (hs == 2'd0) ? hi : (hs == 2'd1) ? 32'h300 : 32'hDEAD4;
    cmd_lo_src = ls; cmd_hi_src = hs; cmd_base = base;
    cmd_stride = {16'(s2), 16'(s1), 16'(s0)};
    cmd_count = {16'(c2), 16'(c1), 16'(c0)};
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!got_done && it < 5000) begin
      it++;
      if (poke && it == 4) begin
        chk(!cmd_ready, "R10", {tag, " ready while busy"}, cmd_ready, 0);
        cmd_valid = 1'b1; cmd_alg = 8'd0;
      end else begin
        cmd_valid = 1'b0; cmd_alg = 8'd3;
      end
      if (err) chk(0, "R10", {tag, " err during run"}, 1, 0);
      rd_rsp_valid = 1'b0;
      if (pend) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data = (pa == 32'h200 || pa == 32'h240) ? lo : hi;
        pend = 0;
      end
      rd_req_ready = 1'b0;
      if (rd_req_valid) begin
        rd_req_ready = 1'b1;
        pa = rd_req_addr;
        if (rdn == 0 && ls != 2'd0) ea = (ls == 2'd1) ? 32'h200 : 32'h240;
        else ea = (hs == 2'd1) ? 32'h300 : 32'h340;
        chk(pa == ea, "R5", {tag, " read address"}, pa, ea);
        rdn++;
        pend = 1;
      end
      wr_ready = bp ? ((cyc % 3) != 1) : 1'b1;
      if (wr_valid && wr_ready) begin
        ea = base + 32'(4 * (j0 * s0 + j1 * s1 + j2 * s2));
        chk(k < total, "R9", {tag, " extra write"}, k, total);
        chk(wr_addr == ea, "R6", {tag, " address"}, wr_addr, ea);
        model_draw(r);
        f = real'(r[31:9]) / 8388608.0;
        ex = lr + f * (hr - lr);
        dr = f2r(wr_data);
        if (exact) chk(dr == ex, "R4", {tag, " exact value"}, wr_data, r[31:9]);
        else begin
          tol = 4.0 * (ex < 0 ? -ex : ex) / 8388608.0;
          chk(dr <= ex && ex - dr <= tol, "R4", {tag, " truncated value"}, wr_data, r[31:9]);
        end
        k++;
        j0++;
        if (j0 == c0) begin j0 = 0; j1++; if (j1 == c1) begin j1 = 0; j2++; end end
      end
      if (done) got_done = 1;
      @(negedge clk);
    end
    cmd_valid = 1'b0; cmd_alg = 8'd3; wr_ready = 1'b0; rd_req_ready = 1'b0; rd_rsp_valid = 1'b0;
    chk(got_done, "R9", {tag, " done seen"}, got_done, 1);
    chk(k == total, "R9", {tag, " write count"}, k, total);
    chk(rdn == int'(ls != 0) + int'(hs != 0), "R5", {tag, " read count"}, rdn, int'(ls != 0) + int'(hs != 0));
    chk(!done && cmd_ready, "R9", {tag, " single done pulse"}, done, 0);
  endtask

  task automatic reject(input logic [7:0] alg, post, fmt, input logic [1:0] ls, hs, input string tag);
    int nerr;
    bit act;
    nerr = 0; act = 0;
    @(negedge clk);
    cmd_alg = alg; cmd_post = post; cmd_fmt = fmt; cmd_lo_src = ls; cmd_hi_src = hs;
    cmd_count = {16'd1, 16'd1, 16'd1};
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (6) begin
      if (err) nerr++;
      if (wr_valid || rd_req_valid || !cmd_ready) act = 1;
      @(negedge clk);
    end
    cmd_alg = 8'd3; cmd_post = 8'd1; cmd_fmt = 8'h0A; cmd_lo_src = 2'd0; cmd_hi_src = 2'd0;
    chk(nerr == 1, "R7", {tag, " err pulses"}, nerr, 1);
    chk(!act, "R7", {tag, " no activity"}, act, 0);
  endtask

  initial begin
    model_seed(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1 && !wr_valid && !done && !err && !rd_req_valid, "R10", "reset idle state",
        {cmd_ready, wr_valid, done, err}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state equals the default words with a zero Weyl counter
    run(32'h00000000, 32'h3F800000, 0, 0, 32'h1000, 1, 3, 6, 3, 2, 2, 1, 0, 0, "R1 R3 reset seed [0,1)");
    seed_load(32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F, 32'hCAFE_BABE, 32'h1357_9BDF, 32'h0000_1111);
    run(32'h40000000, 32'h40800000, 1, 2, 32'h8000, -1, 5, -20, 2, 3, 2, 1, 0, 0, "R5 R6 [2,4) ptr+reg");
    run(32'hBF800000, 32'h3F800000, 2, 1, 32'h4000, 2, -7, 64, 4, 3, 3, 1, 1, 1, "R8 R10 [-1,1) backpressure");
    run(32'h3DCCCCCD, 32'h3F333333, 1, 1, 32'h0, 1, 8, 32, 5, 4, 2, 0, 1, 0, "R4 [0.1,0.7) inexact");
    seed_load(0, 0, 0, 0, 0, 32'hABCD_0001);
    run(32'h00000000, 32'h3F800000, 0, 0, 32'h2000, 1, 2, 4, 2, 2, 2, 1, 0, 0, "R2 zero seed default");
    reject(8'd0, 8'd1, 8'h0A, 0, 0, "R7 alg0");
    reject(8'd2, 8'd1, 8'h0A, 0, 0, "R7 alg2");
    reject(8'd3, 8'd0, 8'h0A, 0, 0, "R7 post0");
    reject(8'd3, 8'd2, 8'h0A, 0, 0, "R7 post2");
    reject(8'd3, 8'd1, 8'h09, 0, 0, "R7 fmt int");
    reject(8'd3, 8'd1, 8'h0A, 3, 0, "R7 lo src3");
    reject(8'd3, 8'd1, 8'h0A, 0, 3, "R7 hi src3");
    cmd_fmt = 8'h0B;
    run(32'h40000000, 32'h40800000, 0, 0, 32'h100, 1, 1, 1, 3, 1, 1, 1, 0, 0, "R7 fmt 0x0B accepted");
    cmd_fmt = 8'h0A;
    run(32'h00000000, 32'h3F800000, 1, 0, 32'h100, 1, 1, 1, 3, 0, 2, 1, 0, 0, "R9 zero count");
    run(32'h40000000, 32'h40800000, 0, 0, 32'h600, 1, 1, 1, 1, 1, 1, 1, 1, 0, "R1 single element");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule